// File: doc/BRIEF.md
# Serial Peripheral Master with Character Queues

This block is a synchronous serial master for a processor bus. Software writes 8-bit characters into an 8-entry transmit queue. Each write carries a ninth bit that marks the final character of a transfer. A start command turns on the active-low select line and shifts characters out MSB first. At the same time the block shifts the incoming line into an 8-entry receive queue. The transfer has no length counter. It ends when the marked character has fully left the shifter. The select line is then released and a completion event is latched.

Clock polarity and sampling phase are programmable, which gives the four usual modes. The bit rate comes from a 6-bit divider. Six event bits report queue service requests, completion, a competing master on the shared select input, receive overrun and transmit starvation. A mask register gates these events onto a level interrupt. When another master is detected, the transfer stops and the pin drivers are turned off until software clears that event.

Top module: `spi_fifo_master`

## Requirements
- R1: After reset, config (0x00) reads 0x0000_0E00: enable, polarity and phase are 0, divider is 0, and the read-only length field [11:9] holds 7 (character length minus one). Mask (0x04) reads 0x3F, status (0x10) reads 0x02 and `irq` is low.
- R2: The divider is config[8:3] (D). While select is low, the serial clock toggles every D+1 cycles. Each character keeps select low for 16*(D+1) cycles.
- R3: Config bit 1 (polarity) sets the idle level of the serial clock. Config bit 2 (phase) picks the sampling edge: 0 samples on the leading edge and 1 samples on the trailing edge. Data moves MSB first in both directions.
- R4: A write to data (0x14) queues wdata[7:0], with wdata[8] as the last-character mark. Select stays low without a break across every character up to and including the marked one, and goes high right after it.
- R5: Event bit 2 (done) sets when the marked character completes.
- R6: Config bit 0 (enable) must be 1 for a start to begin a transfer. With enable at 0, select stays high. Clearing enable aborts a running transfer.
- R7: Control (0x08) write bits are: 0 clears the receive queue, 1 clears the transmit queue, 2 starts. Control always reads 0.
- R8: Status bits are: 0 transmit queue full, 1 receive queue empty, 2 enabled, 3 an unmasked event is pending, 4 busy.
- R9: Event bit 0 follows "transmit queue not full" and event bit 1 follows "receive queue not empty".
- R10: Event bit 5 sets when a character is needed and the transmit queue is empty. This covers a start with an empty queue and a queue that runs dry before the marked character. The transfer then stops with select high and done is not set.
- R11: Event bit 4 sets when a character completes while the receive queue is full. The new character is dropped and the queued ones are kept.
- R12: If `ss_in_n` goes low while the block is enabled, event bit 3 sets, the transfer aborts with select high, and `pins_oe` stays low until bit 3 is cleared.
- R13: Event bits 2 to 5 stay set until 1 is written to them. `irq` is high exactly when some event bit is set and its mask bit (same position) is 0.
- R14: A read of data (0x14) returns the oldest received character in bits [7:0] with bits [31:8] zero, and pops it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops data on 0x14) |
| reg_addr | input | 5 | Byte address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from reg_addr |
| irq | output | 1 | Level interrupt |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| cs_n_o | output | 1 | Active-low select |
| pins_oe | output | 1 | Output enable for clock, data and select |
| ss_in_n | input | 1 | Shared select line, low when another master drives it |

## Verification
Some properties are checked on every cycle. The clock half-period while select is low, the idle clock level whenever select is high, select staying high while disabled or after a master conflict, and the zero upper bits on control and data reads.

Other behaviour only shows up in the bench's scenarios. These are the bit order and sampling edge in each mode, which an independent slave model and an inverting loopback check. Also the unbroken select across a multi-character transfer, underflow and overrun handling, the queue clear commands, and the interrupt gating through the mask.

// File: rtl/spi_fifo_master_pkg.sv
// Shared constants for the serial master: register offsets, event bit
// positions and the shifter state type.
package spi_fifo_master_pkg;
    localparam int EV_W     = 6;
    localparam int EV_TXREQ = 0;
    localparam int EV_RXREQ = 1;
    localparam int EV_DONE  = 2;
    localparam int EV_MULTI = 3;
    localparam int EV_ROVF  = 4;
    localparam int EV_TUNF  = 5;

    localparam logic [4:0] A_CFG  = 5'h00;
    localparam logic [4:0] A_MASK = 5'h04;
    localparam logic [4:0] A_CTRL = 5'h08;
    localparam logic [4:0] A_EVT  = 5'h0C;
    localparam logic [4:0] A_STAT = 5'h10;
    localparam logic [4:0] A_DATA = 5'h14;

    typedef enum logic {SH_IDLE, SH_RUN} sh_state_t;
endpackage

// File: rtl/sfm_fifo.sv
// Synchronous first-in first-out queue.
// Assumes: a push when full and a pop when empty are dropped; clr wins
// over push and pop; rdata shows the head entry without a pop.
module sfm_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             push,
    input  logic [WIDTH-1:0] wdata,
    input  logic             pop,
    output logic [WIDTH-1:0] rdata,
    output logic             full,
    output logic             empty
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_q, rd_q;
    logic [CNT_W-1:0] cnt_q;
    logic do_push, do_pop;

    assign full    = (cnt_q == CNT_W'(DEPTH));
    assign empty   = (cnt_q == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rdata   = mem[rd_q];

    // Storage write port.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_q] <= wdata;
    end

    // Pointer and occupancy tracking.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (do_push) wr_q <= (wr_q == PTR_W'(DEPTH-1)) ? '0 : wr_q + 1'b1;
            if (do_pop)  rd_q <= (rd_q == PTR_W'(DEPTH-1)) ? '0 : rd_q + 1'b1;
            if (do_push && !do_pop)      cnt_q <= cnt_q + 1'b1;
            else if (do_pop && !do_push) cnt_q <= cnt_q - 1'b1;
        end
    end
endmodule

// File: rtl/sfm_shifter.sv
// Bit engine: rate divider, clock edge sequencing, transmit and receive
// shift registers and select control. Each character takes 2*CHAR_BITS
// half-periods. Even edges are leading, odd edges are trailing.
// Assumes: brg, cpol and cpha stay stable while busy. Abort is honoured
// before any other action.
module sfm_shifter
    import spi_fifo_master_pkg::*;
#(
    parameter int CHAR_BITS = 8,
    parameter int BRG_W     = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en,
    input  logic                 cpol,
    input  logic                 cpha,
    input  logic [BRG_W-1:0]     brg,
    input  logic                 start,
    input  logic                 abort,
    input  logic                 tx_empty,
    input  logic [CHAR_BITS:0]   tx_data,
    input  logic                 miso,
    output logic                 tx_pop,
    output logic                 rx_push,
    output logic [CHAR_BITS-1:0] rx_data,
    output logic                 done_pls,
    output logic                 unf_pls,
    output logic                 busy,
    output logic                 sck,
    output logic                 mosi,
    output logic                 cs_n
);
    localparam int EDGES  = 2 * CHAR_BITS;
    localparam int EDGE_W = $clog2(EDGES);

    sh_state_t            state_q;
    logic [BRG_W-1:0]     div_q;
    logic [EDGE_W-1:0]    edge_q;
    logic                 sck_q, out_q, last_q, cs_q;
    logic [CHAR_BITS-1:0] shtx_q, shrx_q, rx_next;
    logic run, tick, lead, samp, drive, char_end, go, want_load, do_load;

    // Edge classification and load decisions.
    always_comb begin
        run       = (state_q == SH_RUN);
        tick      = run && (div_q == brg);
        lead      = ~edge_q[0];
        samp      = tick && (lead ^ cpha);
        drive     = tick && !(lead ^ cpha);
        char_end  = tick && (edge_q == EDGE_W'(EDGES-1));
        go        = start && en && !abort && !run;
        want_load = go || (char_end && !last_q && !abort);
        do_load   = want_load && !tx_empty;
        rx_next   = samp ? {shrx_q[CHAR_BITS-2:0], miso} : shrx_q;
    end

    assign tx_pop   = do_load;
    assign unf_pls  = want_load && tx_empty;
    assign rx_push  = char_end && !abort;
    assign done_pls = char_end && last_q && !abort;
    assign rx_data  = rx_next;
    assign busy     = run;
    assign sck      = sck_q ^ cpol;
    assign mosi     = out_q;
    assign cs_n     = cs_q;

    // Sequencing of divider, edges, shifting and select.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SH_IDLE;
            div_q   <= '0;
            edge_q  <= '0;
            sck_q   <= 1'b0;
            out_q   <= 1'b0;
            last_q  <= 1'b0;
            cs_q    <= 1'b1;
            shtx_q  <= '0;
            shrx_q  <= '0;
        end else if (run && abort) begin
            state_q <= SH_IDLE;
            div_q   <= '0;
            edge_q  <= '0;
            sck_q   <= 1'b0;
            cs_q    <= 1'b1;
        end else begin
            if (tick) begin
                div_q  <= '0;
                sck_q  <= ~sck_q;
                edge_q <= char_end ? '0 : edge_q + 1'b1;
                shrx_q <= rx_next;
                if (drive) begin
                    out_q  <= shtx_q[CHAR_BITS-1];
                    shtx_q <= shtx_q << 1;
                end
            end else if (run) begin
                div_q <= div_q + 1'b1;
            end
            if (char_end && !do_load) begin
                state_q <= SH_IDLE;
                cs_q    <= 1'b1;
            end
            if (do_load) begin
                state_q <= SH_RUN;
                cs_q    <= 1'b0;
                last_q  <= tx_data[CHAR_BITS];
                if (!cpha) begin
                    out_q  <= tx_data[CHAR_BITS-1];
                    shtx_q <= tx_data[CHAR_BITS-1:0] << 1;
                end else begin
                    shtx_q <= tx_data[CHAR_BITS-1:0];
                end
            end
        end
    end
endmodule

// File: rtl/spi_fifo_master.sv
// Register front end of the serial master: configuration, mask, command,
// event and status registers, the two character queues and the bit engine.
// Assumes: reg_rdata is sampled in the cycle reg_rd is high. A data read
// pops in that cycle. ss_in_n is asynchronous and is synchronised here.
module spi_fifo_master
    import spi_fifo_master_pkg::*;
#(
    parameter int DEPTH     = 8,
    parameter int CHAR_BITS = 8,
    parameter int BRG_W     = 6
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [4:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        irq,
    output logic        sclk_o,
    output logic        mosi_o,
    input  logic        miso_i,
    output logic        cs_n_o,
    output logic        pins_oe,
    input  logic        ss_in_n
);
    localparam int LEN_W = $clog2(CHAR_BITS);
    localparam int STK_W = EV_W - 2;

    logic              cfg_en, cfg_cpol, cfg_cpha;
    logic [BRG_W-1:0]  cfg_brg;
    logic [EV_W-1:0]   mask_q, ev_view;
    logic [STK_W-1:0]  stk_q, w1c;
    logic              ss_meta, ss_sync, mm_hit, abort;
    logic              wr_cfg, wr_mask, wr_ctrl, wr_evt, wr_data, rd_data;
    logic              tx_full, tx_empty, tx_pop, rx_full, rx_empty, rx_push;
    logic [CHAR_BITS:0]   tx_head;
    logic [CHAR_BITS-1:0] rx_head, rx_char;
    logic              done_pls, unf_pls, busy, unused_wdata;

    assign unused_wdata = ^reg_wdata;
    assign wr_cfg  = reg_wr && (reg_addr == A_CFG);
    assign wr_mask = reg_wr && (reg_addr == A_MASK);
    assign wr_ctrl = reg_wr && (reg_addr == A_CTRL);
    assign wr_evt  = reg_wr && (reg_addr == A_EVT);
    assign wr_data = reg_wr && (reg_addr == A_DATA);
    assign rd_data = reg_rd && (reg_addr == A_DATA);
    assign w1c     = wr_evt ? reg_wdata[EV_W-1:2] : '0;
    assign mm_hit  = cfg_en && !ss_sync;
    assign abort   = mm_hit || stk_q[EV_MULTI-2] || !cfg_en;
    assign ev_view = {stk_q, !rx_empty, !tx_full};
    assign irq     = |(ev_view & ~mask_q);
    assign pins_oe = cfg_en && !stk_q[EV_MULTI-2];

    // Configuration and mask registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_en   <= 1'b0;
            cfg_cpol <= 1'b0;
            cfg_cpha <= 1'b0;
            cfg_brg  <= '0;
            mask_q   <= '1;
        end else begin
            if (wr_cfg) begin
                cfg_en   <= reg_wdata[0];
                cfg_cpol <= reg_wdata[1];
                cfg_cpha <= reg_wdata[2];
                cfg_brg  <= reg_wdata[3 +: BRG_W];
            end
            if (wr_mask) mask_q <= reg_wdata[EV_W-1:0];
        end
    end

    // Two-flop synchroniser for the shared select input.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ss_meta <= 1'b1;
            ss_sync <= 1'b1;
        end else begin
            ss_meta <= ss_in_n;
            ss_sync <= ss_meta;
        end
    end

    // Sticky events: set by hardware, cleared by writing one.
    always_ff @(posedge clk) begin
        if (!rst_n) stk_q <= '0;
        else stk_q <= (stk_q & ~w1c)
                    | {unf_pls, rx_push && rx_full, mm_hit, done_pls};
    end

    // Register read multiplexer.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_CFG: begin
                reg_rdata[0]                = cfg_en;
                reg_rdata[1]                = cfg_cpol;
                reg_rdata[2]                = cfg_cpha;
                reg_rdata[3 +: BRG_W]       = cfg_brg;
                reg_rdata[3+BRG_W +: LEN_W] = LEN_W'(CHAR_BITS-1);
            end
            A_MASK: reg_rdata[EV_W-1:0] = mask_q;
            A_EVT:  reg_rdata[EV_W-1:0] = ev_view;
            A_STAT: reg_rdata[4:0] = {busy, irq, cfg_en, rx_empty, tx_full};
            A_DATA: reg_rdata[CHAR_BITS-1:0] = rx_head;
            default: reg_rdata = '0;
        endcase
    end

    sfm_fifo #(.WIDTH(CHAR_BITS+1), .DEPTH(DEPTH)) tx_q_i (
        .clk(clk), .rst_n(rst_n), .clr(wr_ctrl && reg_wdata[1]),
        .push(wr_data), .wdata(reg_wdata[CHAR_BITS:0]), .pop(tx_pop),
        .rdata(tx_head), .full(tx_full), .empty(tx_empty));

    sfm_fifo #(.WIDTH(CHAR_BITS), .DEPTH(DEPTH)) rx_q_i (
        .clk(clk), .rst_n(rst_n), .clr(wr_ctrl && reg_wdata[0]),
        .push(rx_push), .wdata(rx_char), .pop(rd_data),
        .rdata(rx_head), .full(rx_full), .empty(rx_empty));

    sfm_shifter #(.CHAR_BITS(CHAR_BITS), .BRG_W(BRG_W)) shift_i (
        .clk(clk), .rst_n(rst_n), .en(cfg_en), .cpol(cfg_cpol),
        .cpha(cfg_cpha), .brg(cfg_brg), .start(wr_ctrl && reg_wdata[2]),
        .abort(abort), .tx_empty(tx_empty), .tx_data(tx_head),
        .miso(miso_i), .tx_pop(tx_pop), .rx_push(rx_push),
        .rx_data(rx_char), .done_pls(done_pls), .unf_pls(unf_pls),
        .busy(busy), .sck(sclk_o), .mosi(mosi_o), .cs_n(cs_n_o));
endmodule

// File: rtl/sfm_checker.sv
// Protocol checker for spi_fifo_master, attached with bind.
// Assumes: the divider is not rewritten while select is low.
module sfm_checker
    import spi_fifo_master_pkg::*;
#(
    parameter int BRG_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cs_n_o,
    input logic             sclk_o,
    input logic             cfg_en,
    input logic             cfg_cpol,
    input logic [BRG_W-1:0] cfg_brg,
    input logic             mm_flag,
    input logic             reg_rd,
    input logic [4:0]       reg_addr,
    input logic [31:0]      reg_rdata
);
    logic             sclk_prev, cs_prev;
    logic [BRG_W:0]   gap_q;

    // Cycles since the serial clock or select last changed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_prev <= 1'b0;
            cs_prev   <= 1'b1;
            gap_q     <= '0;
        end else begin
            sclk_prev <= sclk_o;
            cs_prev   <= cs_n_o;
            if (sclk_o != sclk_prev || cs_n_o != cs_prev) gap_q <= '0;
            else if (gap_q != '1) gap_q <= gap_q + 1'b1;
        end
    end

    // R2
    half_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_o != sclk_prev && !cs_n_o && !cs_prev) |-> gap_q == {1'b0, cfg_brg});
    // R3
    idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_o |-> sclk_o == cfg_cpol);
    // R6
    off_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_en |=> cs_n_o);
    // R12
    conflict_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mm_flag |-> cs_n_o);
    // R7
    ctrl_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == A_CTRL) |-> reg_rdata == 32'h0);
    // R14
    data_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == A_DATA) |-> reg_rdata[31:8] == 24'h0);
endmodule

bind spi_fifo_master sfm_checker #(.BRG_W(BRG_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .cs_n_o(cs_n_o), .sclk_o(sclk_o),
    .cfg_en(cfg_en), .cfg_cpol(cfg_cpol), .cfg_brg(cfg_brg),
    .mm_flag(stk_q[1]), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_rdata(reg_rdata));

// File: tb/spi_fifo_master_tb_top.sv
`timescale 1ns/1ps
module spi_fifo_master_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq, sclk_o, mosi_o, miso_i, cs_n_o, pins_oe;
    logic        ss_in_n = 1'b1;

    int checks = 0, fails = 0;
    int cs_low_cnt = 0, cs_fall_cnt = 0;
    logic cs_neg = 1'b1;
    logic cur_cpol = 1'b0, cur_cpha = 1'b0;
    logic [31:0] s_cap = '0;
    logic [31:0] rv;

    typedef struct packed {
        logic       cpol;
        logic       cpha;
        logic [5:0] brg;
        logic [7:0] dat;
    } vec_t;
    localparam vec_t VECS [6] = '{
        '{1'b0, 1'b0, 6'd0, 8'hA5},
        '{1'b0, 1'b1, 6'd1, 8'h3C},
        '{1'b1, 1'b0, 6'd2, 8'h81},
        '{1'b1, 1'b1, 6'd0, 8'h5E},
        '{1'b0, 1'b0, 6'd5, 8'hFF},
        '{1'b1, 1'b1, 6'd3, 8'h00}
    };

    always #4 clk = ~clk;
    assign miso_i = ~mosi_o;

    spi_fifo_master dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq(irq), .sclk_o(sclk_o), .mosi_o(mosi_o), .miso_i(miso_i),
        .cs_n_o(cs_n_o), .pins_oe(pins_oe), .ss_in_n(ss_in_n));

    // Select activity seen between edges.
    always @(negedge clk) begin
        if (!cs_n_o) cs_low_cnt++;
        if (cs_neg && !cs_n_o) cs_fall_cnt++;
        cs_neg = cs_n_o;
    end

    // Independent slave model: captures the data line on the sampling edge.
    always @(sclk_o) begin
        if (!cs_neg && (sclk_o == (cur_cpha ? cur_cpol : !cur_cpol)))
            s_cap = {s_cap[30:0], mosi_o};
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic wait_idle();
        logic [31:0] st;
        for (int i = 0; i < 20000; i++) begin
            rd(5'h10, st);
            if (!st[4]) break;
        end
    endtask

    task automatic mark_start(input logic pol, input logic pha);
        cur_cpol = pol; cur_cpha = pha;
        s_cap = '0; cs_low_cnt = 0; cs_fall_cnt = 0;
    endtask

    function automatic logic [31:0] cfgv(input logic pol, input logic pha, input logic [5:0] b);
        return {23'd0, b, pha, pol, 1'b1};
    endfunction

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired before the run finished");
        report();
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset values
        rd(5'h00, rv); chk("R1 config", rv, 32'h0000_0E00);
        rd(5'h04, rv); chk("R1 mask", rv, 32'h3F);
        rd(5'h10, rv); chk("R1 status", rv, 32'h02);
        chk("R1 irq", {31'd0, irq}, 32'd0);
        rd(5'h0C, rv); chk("R9 reset events", rv, 32'h01);

        // R6 start without enable does nothing
        mark_start(1'b0, 1'b0);
        wr(5'h14, 32'h1A5);
        wr(5'h08, 32'h4);
        repeat (40) @(negedge clk);
        chk("R6 select stays high", cs_low_cnt, 0);
        rd(5'h0C, rv); chk("R6 no done", {31'd0, rv[2]}, 32'd0);
        wr(5'h08, 32'h2);
        rd(5'h08, rv); chk("R7 control reads zero", rv, 32'd0);

        // Table walk: one marked character per mode and divider
        foreach (VECS[i]) begin
            wr(5'h00, cfgv(VECS[i].cpol, VECS[i].cpha, VECS[i].brg));
            wr(5'h0C, 32'h3F);
            chk("R3 idle level", {31'd0, sclk_o}, {31'd0, VECS[i].cpol});
            mark_start(VECS[i].cpol, VECS[i].cpha);
            wr(5'h14, {23'd0, 1'b1, VECS[i].dat});
            wr(5'h08, 32'h4);
            wait_idle();
            chk("R2 select low cycles", cs_low_cnt, 16 * (VECS[i].brg + 1));
            chk("R3 slave captured", {24'd0, s_cap[7:0]}, {24'd0, VECS[i].dat});
            rd(5'h0C, rv); chk("R5 done event", {31'd0, rv[2]}, 32'd1);
            rd(5'h14, rv); chk("R14 received", rv, {24'd0, ~VECS[i].dat});
            chk("R3 idle after", {31'd0, sclk_o}, {31'd0, VECS[i].cpol});
        end

        // R4 three characters under one select
        wr(5'h00, cfgv(1'b0, 1'b0, 6'd1));
        mark_start(1'b0, 1'b0);
        wr(5'h14, 32'h011); wr(5'h14, 32'h022); wr(5'h14, 32'h133);
        wr(5'h08, 32'h4);
        wait_idle();
        chk("R4 one select fall", cs_fall_cnt, 1);
        chk("R4 select low cycles", cs_low_cnt, 96);
        chk("R4 slave bytes", {8'd0, s_cap[23:0]}, 32'h0011_2233);
        rd(5'h14, rv); chk("R14 first byte", rv, 32'hEE);
        rd(5'h14, rv); chk("R14 second byte", rv, 32'hDD);
        rd(5'h14, rv); chk("R14 third byte", rv, 32'hCC);

        // R8 R9 full transmit queue, then clear
        for (int k = 0; k < 8; k++) wr(5'h14, 32'h40 + k);
        rd(5'h10, rv); chk("R8 tx full", {31'd0, rv[0]}, 32'd1);
        rd(5'h0C, rv); chk("R9 tx request low", {31'd0, rv[0]}, 32'd0);
        wr(5'h08, 32'h2);
        rd(5'h10, rv); chk("R7 tx cleared", {31'd0, rv[0]}, 32'd0);

        // R11 receive overrun
        wr(5'h0C, 32'h3F);
        for (int k = 0; k < 8; k++) wr(5'h14, (k == 7 ? 32'h100 : 32'h0) | (32'h10 + k));
        wr(5'h08, 32'h4);
        wait_idle();
        rd(5'h0C, rv); chk("R9 rx request", {31'd0, rv[1]}, 32'd1);
        chk("R11 no overrun yet", {31'd0, rv[4]}, 32'd0);
        wr(5'h14, 32'h199);
        wr(5'h08, 32'h4);
        wait_idle();
        rd(5'h0C, rv); chk("R11 overrun", {31'd0, rv[4]}, 32'd1);
        rd(5'h14, rv); chk("R11 oldest kept", rv, 32'hEF);
        wr(5'h08, 32'h1);
        rd(5'h10, rv); chk("R7 rx cleared", {31'd0, rv[1]}, 32'd1);

        // R10 queue runs dry before a marked character
        wr(5'h0C, 32'h3F);
        mark_start(1'b0, 1'b0);
        wr(5'h14, 32'h055);
        wr(5'h08, 32'h4);
        wait_idle();
        rd(5'h0C, rv);
        chk("R10 underflow", {31'd0, rv[5]}, 32'd1);
        chk("R10 no done", {31'd0, rv[2]}, 32'd0);
        chk("R10 one character", cs_low_cnt, 32);
        wr(5'h0C, 32'h3F);
        mark_start(1'b0, 1'b0);
        wr(5'h08, 32'h4);
        repeat (10) @(negedge clk);
        rd(5'h0C, rv); chk("R10 empty start", {31'd0, rv[5]}, 32'd1);
        chk("R10 select untouched", cs_fall_cnt, 0);

        // R13 masking and write-one-to-clear
        wr(5'h08, 32'h1);
        wr(5'h04, 32'h1F);
        chk("R13 irq on", {31'd0, irq}, 32'd1);
        rd(5'h10, rv); chk("R8 summary bit", {31'd0, rv[3]}, 32'd1);
        wr(5'h0C, 32'h20);
        chk("R13 irq off", {31'd0, irq}, 32'd0);
        rd(5'h0C, rv); chk("R13 cleared", {31'd0, rv[5]}, 32'd0);
        wr(5'h04, 32'h3F);

        // R12 competing master aborts the transfer
        wr(5'h00, cfgv(1'b0, 1'b0, 6'd5));
        wr(5'h14, 32'h1C3);
        wr(5'h08, 32'h4);
        repeat (20) @(negedge clk);
        ss_in_n = 1'b0;
        repeat (5) @(negedge clk);
        ss_in_n = 1'b1;
        chk("R12 select released", {31'd0, cs_n_o}, 32'd1);
        chk("R12 drivers off", {31'd0, pins_oe}, 32'd0);
        rd(5'h0C, rv); chk("R12 conflict event", {31'd0, rv[3]}, 32'd1);
        rd(5'h10, rv); chk("R12 not busy", {31'd0, rv[4]}, 32'd0);
        wr(5'h0C, 32'h08);
        chk("R12 drivers back", {31'd0, pins_oe}, 32'd1);

        report();
    end
endmodule